// File: doc/BRIEF.md
# Link-Down Recovery Watchdog

This block watches a link-status input. When the link stays down for a fixed interval, it nudges the attached transceiver with a limited logic reset. It samples a link-up signal and a loopback-active signal on every clock. A prescaler divides the clock into ticks, and an interval counter counts those ticks. The counter starts again from zero whenever the sampled link is up, whenever loopback is active, and whenever a recovery is in progress. When the count runs out while the link is down and no loopback is active, the block starts a recovery.

A recovery is a read-modify-write of a command word in the transceiver. The block reads the word, then writes it back with the reset bit set and every other bit unchanged. The reset bit clears itself. The block then reads the word again at fixed spacing until it sees the bit low. If the bit is still high after a bounded number of polls, the block raises a sticky timeout flag, which stays set until it is cleared by a pulse. A separate output pulses for one cycle whenever the sampled link state changes.

The command word is reached through a simple port: a one-cycle read strobe, a read-data-valid response, and a one-cycle write strobe with its data. The transceiver's own reset logic sits outside the block as a responder on that port.

Top module: `link_recovery_wdog`

## Requirements
- R1: With the link and loopback samples low and the block idle, the read strobe of a recovery rises INTERVAL_TICKS*TICK_DIV cycles after the first such idle cycle. One cycle later than that is the sampling register's delay, counted from the cycle in which linkUp falls.
- R2: No recovery starts while the sampled link is up or loopback is active. When both drop, the interval count restarts from zero, with the same delay as R1.
- R3: After a recovery ends, the next one (if the link is still down) starts INTERVAL_TICKS*TICK_DIV+1 cycles after the cycle that carried the final poll response.
- R4: Each recovery issues exactly one read and then exactly one write of the command word, and the written data has bit RESET_BIT (default 14) set.
- R5: The written data equals the word returned by that recovery's first read in every bit other than RESET_BIT.
- R6: After the write, the block polls the command word and ends the recovery on the first response with bit RESET_BIT clear, without setting the timeout flag. The number of poll reads equals the number of set responses plus one.
- R7: If POLL_LIMIT poll responses all show bit RESET_BIT set, the block makes exactly POLL_LIMIT poll reads and sets timeoutFlag in the cycle after the last response.
- R8: timeoutFlag stays set until a timeoutClear pulse and is low in the cycle after that pulse.
- R9: linkChange is high for one cycle, one cycle after linkUp changes level.
- R10: During reset, cmdRdEn, cmdWrEn, timeoutFlag and linkChange are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link status from the transceiver |
| loopbackActive | input | 1 | High while any loopback mode is in use |
| timeoutClear | input | 1 | Pulse to clear the sticky timeout flag |
| cmdRdEn | output | 1 | One-cycle read strobe for the command word |
| cmdRdValid | input | 1 | Read response valid |
| cmdRdData | input | CMD_W | Read response data |
| cmdWrEn | output | 1 | One-cycle write strobe for the command word |
| cmdWrData | output | CMD_W | Write data: the captured word with the reset bit set |
| timeoutFlag | output | 1 | Sticky: reset bit failed to clear within the poll budget |
| linkChange | output | 1 | One-cycle pulse on a change of sampled link state |

## Verification
Suppose the interval counter or prescaler holds a wrong count, or misses a restart. The first read of a recovery then lands on the wrong cycle, and that shows on cmdRdEn within one interval. A bad captured word or mask shows at once on cmdWrData in the single write cycle. A bad poll counter shows as a wrong number of read strobes before the sequence ends, or as a wrong timeoutFlag one cycle after the last response. A sequencer stuck in a busy state shows as missing read strobes, which the next expected start time reveals.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_WRITE,
    ST_GAP,
    ST_POLL_RD,
    ST_WAIT_POLL
  } lrwState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic timerHold;   // sequence in progress, keep interval at zero
    logic capture;     // latch the read response
    logic pollClear;   // restart the poll counter
    logic pollInc;     // one more poll consumed
    logic gapLoad;     // start a poll spacing interval
    logic setTimeout;  // poll budget exhausted
  } lrwStrobes_t;

endpackage

// File: rtl/lrw_datapath.sv
module lrw_datapath
  import lrw_pkg::*;
#(
  parameter int TICK_DIV       = 125,
  parameter int INTERVAL_TICKS = 5000000,
  parameter int POLL_LIMIT     = 50,
  parameter int POLL_GAP       = 125,
  parameter int CMD_W          = 16,
  parameter int RESET_BIT      = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkUp,
  input  logic             loopbackActive,
  input  logic             timeoutClear,
  input  lrwStrobes_t      strb,
  input  logic [CMD_W-1:0] cmdRdData,
  output logic             expire,
  output logic             gapDone,
  output logic             pollLast,
  output logic             pollBit,
  output logic             linkState,
  output logic             loopState,
  output logic [CMD_W-1:0] cmdWrData,
  output logic             timeoutFlag,
  output logic             linkChange
);

  localparam int IVL_W  = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GAP_W  = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [IVL_W-1:0]  IVL_LAST  = IVL_W'(INTERVAL_TICKS - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(POLL_GAP - 1);
  localparam logic [CMD_W-1:0]  RST_MASK  = CMD_W'(1) << RESET_BIT;

  logic linkQ, loopQ;
  logic hold, tick;
  logic [IVL_W-1:0]  ivlCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [CMD_W-1:0]  capWord;

  // input sampling and change detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkQ      <= 1'b0;
      loopQ      <= 1'b0;
      linkChange <= 1'b0;
    end else begin
      linkQ      <= linkUp;
      loopQ      <= loopbackActive;
      linkChange <= linkUp != linkQ;
    end
  end

  assign linkState = linkQ;
  assign loopState = loopQ;
  assign hold      = strb.timerHold | linkQ | loopQ;

  // tick prescaler, absent when every clock is a tick
  if (TICK_DIV > 1) begin : g_prescale
    localparam int PRE_W = $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    logic [PRE_W-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (!rstN)               preCnt <= '0;
      else if (hold || tick)   preCnt <= '0;
      else                     preCnt <= preCnt + 1'b1;
    end
    assign tick = (preCnt == PRE_LAST);
  end else begin : g_noprescale
    assign tick = 1'b1;
  end

  // interval counter in ticks
  always_ff @(posedge clk) begin
    if (!rstN)      ivlCnt <= '0;
    else if (hold)  ivlCnt <= '0;
    else if (tick)  ivlCnt <= (ivlCnt == IVL_LAST) ? '0 : ivlCnt + 1'b1;
  end

  assign expire = !hold && tick && (ivlCnt == IVL_LAST);

  // poll spacing
  always_ff @(posedge clk) begin
    if (!rstN)                gapCnt <= '0;
    else if (strb.gapLoad)    gapCnt <= GAP_LAST;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone = (gapCnt == '0);

  // poll budget
  always_ff @(posedge clk) begin
    if (!rstN)                pollCnt <= '0;
    else if (strb.pollClear)  pollCnt <= '0;
    else if (strb.pollInc)    pollCnt <= pollCnt + 1'b1;
  end

  assign pollLast = (pollCnt == POLL_LAST);
  assign pollBit  = cmdRdData[RESET_BIT];

  // read-modify-write word
  always_ff @(posedge clk) begin
    if (!rstN)              capWord <= '0;
    else if (strb.capture)  capWord <= cmdRdData;
  end

  assign cmdWrData = capWord | RST_MASK;

  // sticky timeout status
  always_ff @(posedge clk) begin
    if (!rstN)                 timeoutFlag <= 1'b0;
    else if (strb.setTimeout)  timeoutFlag <= 1'b1;
    else if (timeoutClear)     timeoutFlag <= 1'b0;
  end

  assert_poll_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_LAST);

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !timeoutClear) |=> timeoutFlag);

  assert_link_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    linkChange == (linkQ != $past(linkQ)));

endmodule

// File: rtl/lrw_ctrl.sv
module lrw_ctrl
  import lrw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        expire,
  input  logic        gapDone,
  input  logic        pollLast,
  input  logic        pollBit,
  input  logic        cmdRdValid,
  output lrwStrobes_t strb,
  output logic        cmdRdEn,
  output logic        cmdWrEn
);

  lrwState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strb           = '0;
    strb.timerHold = (state != ST_IDLE);
    cmdRdEn        = 1'b0;
    cmdWrEn        = 1'b0;
    unique case (state)
      ST_IDLE:      if (expire) stateNext = ST_READ;
      ST_READ: begin
        cmdRdEn   = 1'b1;
        stateNext = ST_WAIT_RD;
      end
      ST_WAIT_RD: if (cmdRdValid) begin
        strb.capture = 1'b1;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: begin
        cmdWrEn        = 1'b1;
        strb.gapLoad   = 1'b1;
        strb.pollClear = 1'b1;
        stateNext      = ST_GAP;
      end
      ST_GAP:       if (gapDone) stateNext = ST_POLL_RD;
      ST_POLL_RD: begin
        cmdRdEn   = 1'b1;
        stateNext = ST_WAIT_POLL;
      end
      ST_WAIT_POLL: if (cmdRdValid) begin
        if (!pollBit) begin
          stateNext = ST_IDLE;
        end else if (pollLast) begin
          strb.setTimeout = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strb.pollInc = 1'b1;
          strb.gapLoad = 1'b1;
          stateNext    = ST_GAP;
        end
      end
      default:      stateNext = ST_IDLE;
    endcase
  end

  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn |-> $past(cmdRdValid));

endmodule

// File: rtl/link_recovery_wdog.sv
module link_recovery_wdog
  import lrw_pkg::*;
#(
  parameter int TICK_DIV       = 125,
  parameter int INTERVAL_TICKS = 5000000,
  parameter int POLL_LIMIT     = 50,
  parameter int POLL_GAP       = 125,
  parameter int CMD_W          = 16,
  parameter int RESET_BIT      = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkUp,
  input  logic             loopbackActive,
  input  logic             timeoutClear,
  output logic             cmdRdEn,
  input  logic             cmdRdValid,
  input  logic [CMD_W-1:0] cmdRdData,
  output logic             cmdWrEn,
  output logic [CMD_W-1:0] cmdWrData,
  output logic             timeoutFlag,
  output logic             linkChange
);

  lrwStrobes_t strb;
  logic expire, gapDone, pollLast, pollBit, linkState, loopState;

  lrw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .expire     (expire),
    .gapDone    (gapDone),
    .pollLast   (pollLast),
    .pollBit    (pollBit),
    .cmdRdValid (cmdRdValid),
    .strb       (strb),
    .cmdRdEn    (cmdRdEn),
    .cmdWrEn    (cmdWrEn)
  );

  lrw_datapath #(
    .TICK_DIV       (TICK_DIV),
    .INTERVAL_TICKS (INTERVAL_TICKS),
    .POLL_LIMIT     (POLL_LIMIT),
    .POLL_GAP       (POLL_GAP),
    .CMD_W          (CMD_W),
    .RESET_BIT      (RESET_BIT)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .linkUp         (linkUp),
    .loopbackActive (loopbackActive),
    .timeoutClear   (timeoutClear),
    .strb           (strb),
    .cmdRdData      (cmdRdData),
    .expire         (expire),
    .gapDone        (gapDone),
    .pollLast       (pollLast),
    .pollBit        (pollBit),
    .linkState      (linkState),
    .loopState      (loopState),
    .cmdWrData      (cmdWrData),
    .timeoutFlag    (timeoutFlag),
    .linkChange     (linkChange)
  );

  assert_start_when_down_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.timerHold) |-> $past(!linkState && !loopState));

  assert_write_sets_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn |-> cmdWrData[RESET_BIT]);

endmodule

// File: tb/sim_link_recovery_wdog.sv
module sim_link_recovery_wdog;

  localparam int TDIV  = 4;
  localparam int NTICK = 10;
  localparam int PGAP  = 3;
  localparam int PLIM  = 5;
  localparam int CW    = 16;
  localparam int RB    = 14;
  localparam int DLY   = TDIV * NTICK + 1;
  localparam logic [CW-1:0] MASK = CW'(1) << RB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkUp = 1'b1;
  logic loopbackActive = 1'b0;
  logic timeoutClear = 1'b0;
  logic cmdRdEn, cmdWrEn, cmdRdValid;
  logic [CW-1:0] cmdRdData, cmdWrData;
  logic timeoutFlag, linkChange;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdCount = 0;

  link_recovery_wdog #(
    .TICK_DIV(TDIV), .INTERVAL_TICKS(NTICK), .POLL_LIMIT(PLIM),
    .POLL_GAP(PGAP), .CMD_W(CW), .RESET_BIT(RB)
  ) u0 (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .loopbackActive(loopbackActive),
    .timeoutClear(timeoutClear), .cmdRdEn(cmdRdEn), .cmdRdValid(cmdRdValid),
    .cmdRdData(cmdRdData), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .timeoutFlag(timeoutFlag), .linkChange(linkChange)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // responder standing in for the transceiver command word
  logic [CW-1:0] cfgPattern = 16'h2A65;
  int  clearAfter = 0;
  bit  stuck = 1'b0;
  int  busyLeft;
  always @(posedge clk) begin
    if (!rstN) begin
      cmdRdValid <= 1'b0;
      cmdRdData  <= '0;
      busyLeft   <= 0;
    end else begin
      cmdRdValid <= cmdRdEn;
      if (cmdRdEn) begin
        cmdRdData <= (cfgPattern & ~MASK) | ((stuck || busyLeft != 0) ? MASK : '0);
        if (!stuck && busyLeft != 0) busyLeft <= busyLeft - 1;
      end
      if (cmdWrEn && cmdWrData[RB]) busyLeft <= clearAfter;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: driver side
  logic [CW-1:0] expQ[$];
  task automatic pushExpect(input logic [CW-1:0] pat);
    expQ.push_back(pat | MASK);
  endtask

  // scoreboard: monitor side
  logic [CW-1:0] popVal;
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdRdEn) rdCount++;
      if (cmdWrEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected write", int'(cmdWrData), 0);
        end else begin
          popVal = expQ.pop_front();
          check(cmdWrData == popVal, "R5", "write data", int'(cmdWrData), int'(popVal));
        end
      end
    end
  end

  task automatic runRecovery(input int startCyc, input int expPolls, input bit expTimeout,
                             input string tag, output int endCyc);
    int polls = 0;
    bit sawWr = 1'b0;
    bit done = 1'b0;
    do @(negedge clk); while (!cmdRdEn);
    check(cyc - startCyc == DLY, tag, "recovery start delay", cyc - startCyc, DLY);
    while (!done) begin
      @(negedge clk);
      if (cmdWrEn) sawWr = 1'b1;
      if (sawWr && cmdRdEn) polls++;
      if (sawWr && cmdRdValid && (!cmdRdData[RB] || polls == PLIM)) done = 1'b1;
    end
    endCyc = cyc;
    check(polls == expPolls, expTimeout ? "R7" : "R6", "poll reads", polls, expPolls);
    @(negedge clk);
    check(timeoutFlag == expTimeout, expTimeout ? "R7" : "R6", "timeout flag",
          int'(timeoutFlag), int'(expTimeout));
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    int c, e, n0;
    repeat (3) @(negedge clk);
    check(!cmdRdEn && !cmdWrEn && !timeoutFlag && !linkChange, "R10", "outputs in reset",
          {cmdRdEn, cmdWrEn, timeoutFlag, linkChange}, 0);
    rstN = 1'b1;

    // link up: nothing happens
    repeat (100) @(negedge clk);
    check(rdCount == 0, "R2", "reads while link up", rdCount, 0);

    // link drops: change pulse, then first recovery
    clearAfter = 2;
    pushExpect(16'h2A65);
    c = cyc;
    linkUp = 1'b0;
    @(negedge clk);
    check(linkChange == 1'b1, "R9", "change pulse high", int'(linkChange), 1);
    @(negedge clk);
    check(linkChange == 1'b0, "R9", "change pulse one cycle", int'(linkChange), 0);
    runRecovery(c, 3, 1'b0, "R1", e);

    // second recovery after timer restart, new configuration word
    cfgPattern = 16'h8123;
    clearAfter = 0;
    pushExpect(16'h8123);
    runRecovery(e, 1, 1'b0, "R3", e);

    // link back up: pulse, then silence
    linkUp = 1'b1;
    @(negedge clk);
    check(linkChange == 1'b1, "R9", "change pulse on rise", int'(linkChange), 1);
    n0 = rdCount;
    repeat (100) @(negedge clk);
    check(rdCount == n0, "R2", "reads after link up", rdCount, n0);

    // loopback keeps the timer reloaded
    loopbackActive = 1'b1;
    linkUp = 1'b0;
    n0 = rdCount;
    repeat (120) @(negedge clk);
    check(rdCount == n0, "R2", "reads during loopback", rdCount, n0);
    clearAfter = 1;
    pushExpect(16'h8123);
    c = cyc;
    loopbackActive = 1'b0;
    runRecovery(c, 2, 1'b0, "R2", e);

    // reset bit never clears
    stuck = 1'b1;
    pushExpect(16'h8123);
    runRecovery(e, PLIM, 1'b1, "R7", e);
    linkUp = 1'b1;
    repeat (20) @(negedge clk);
    check(timeoutFlag == 1'b1, "R8", "flag held", int'(timeoutFlag), 1);
    timeoutClear = 1'b1;
    @(negedge clk);
    timeoutClear = 1'b0;
    check(timeoutFlag == 1'b0, "R8", "flag cleared", int'(timeoutFlag), 0);
    check(expQ.size() == 0, "R4", "writes outstanding", expQ.size(), 0);

    finishRun();
  end

endmodule